// File: doc/BRIEF.md
# Data Access Translation Checker

This unit turns the virtual address of a load or store into a physical address. On the way it applies every check the access needs: natural alignment, canonical form of the address, a kernel-only direct-mapped window, the result of a translation lookup, and the per-mode read and write enables of the page. When a check fails, the unit does not produce an address. It reports one fault class and a status vector that tells the handler why the access was refused.

The translation store lives outside the block. The unit drives the page number and address-space number to it, and it expects the hit flag, the page frame and the permission bits back in the same cycle. The verdict is registered and appears one cycle after the request. Six counters track hits, misses and violations separately for loads and for stores, and three sum outputs combine the two kinds.

While privileged code runs (program-counter low bit set), the mode used for the page permission check is kernel. If the request asks for alternate mode, the alternate mode is used instead.

Top module: `dxc_xlate_check`

## Requirements
- R1: The access size code selects 1, 2, 4 or 8 bytes (code 0 to 3). An address that is not a multiple of the size gives fault code 1, ahead of every other check. Its status is status bit 0 (store) for a store and all zero for a load. No counter changes.
- R2: The permission bit indexed by the mode is used, with modes encoded as 0 kernel, 1 executive, 2 supervisor and 3 user. When the program-counter low bit is set, that mode is kernel, or the alternate mode if the alternate flag is set. Otherwise it is the current mode.
- R3: With the physical flag set, the physical address is the virtual address unchanged, and the access counts as a hit of its kind.
- R4: An address whose bits 63 to 42 are not all equal gives fault code 2. Its status has bit 1 (violation) and bit 4 (bad address) set, plus bit 0 for a store. It counts as a violation.
- R5: An address with bits 47 to 41 equal to 0x7E maps directly when the current mode is kernel. The result is bits 39 to 0, with bits 43 to 40 all copies of bit 40. In any other current mode the access gives fault code 3, with status bit 1 (plus bit 0 for a store), and counts as a violation.
- R6: A lookup miss gives fault code 4 if the request is a page-table-entry fetch and code 5 otherwise. Its status has bit 5 (miss) set, plus bit 0 for a store. It counts as a miss.
- R7: On a lookup hit the physical address is the page frame shifted left by 13, joined with address bits 12 to 0.
- R8: A store whose write-enable bit for the mode is clear gives fault code 2. Its status has bits 0 and 1 set, and bit 3 if the page's fault-on-write bit is set.
- R9: A permitted store to a page with fault-on-write set gives fault code 2, with status bits 0 and 3 only.
- R10: A load whose read-enable bit is clear gives fault code 3, with status bit 1 and bit 2 if fault-on-read is set. A permitted load with fault-on-read set gives fault code 2 with status bit 2 only. Both count as violations.
- R11: A resulting address with any bit above bit 43 set gives fault code 6 (machine check) with zero status. The access is still counted as a hit.
- R12: A fault-free result with bit 43 set raises the uncacheable flag and clears bits 42 to 35 of the physical address.
- R13: The verdict and the counter updates appear one cycle after a valid request. Only the counters of the request's kind (load or store) change. Each sum output equals the load count plus the store count. A cycle with no request changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Access size code (0..3 = 1..8 bytes) |
| req_write | input | 1 | 1 for a store |
| req_phys | input | 1 | Use the address as physical |
| req_alt | input | 1 | Use the alternate mode under privileged code |
| req_pte | input | 1 | Request is a page-table-entry fetch |
| cur_mode | input | 2 | Current mode |
| alt_mode | input | 2 | Alternate mode |
| pc_low | input | 1 | Program-counter low bit |
| asn | input | 8 | Address-space number |
| lk_vpn | output | 30 | Page number sent to the lookup |
| lk_asn | output | 8 | Address-space number sent to the lookup |
| tlb_hit | input | 1 | Lookup found a matching page |
| tlb_ppn | input | 31 | Page frame from the lookup |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault-on-read page bit |
| tlb_fonw | input | 1 | Fault-on-write page bit |
| out_valid | output | 1 | Verdict valid |
| out_pa | output | 44 | Physical address |
| out_uncache | output | 1 | Access is uncacheable |
| out_fault | output | 3 | Fault code (0 none) |
| out_status | output | 6 | Status vector |
| rd_hits | output | 16 | Load hits |
| rd_misses | output | 16 | Load misses |
| rd_viols | output | 16 | Load violations |
| wr_hits | output | 16 | Store hits |
| wr_misses | output | 16 | Store misses |
| wr_viols | output | 16 | Store violations |
| all_hits | output | 17 | Sum of hits |
| all_misses | output | 17 | Sum of misses |
| all_viols | output | 17 | Sum of violations |

## Verification
The permission check and the physical-address finishing can act on the same request. One case is a TLB hit on a high page frame, which sets the uncacheable bit while the page's fault-on bits are live. Another is a physical-mode address with high bits set, which gives a machine check that still counts as a hit. The bench drives both combinations directly and through random page frames. It then judges the fault code, the masked address and the counter of the request's kind against its own model. Alignment is also placed on top of invalid and window addresses to confirm that it wins.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
    localparam int VA_W       = 64;
    localparam int SIGN_BIT   = 42;
    localparam int PAGE_SHIFT = 13;
    localparam int PA_W       = 44;
    localparam int PPN_W      = PA_W - PAGE_SHIFT;
    localparam int VPN_W      = SIGN_BIT + 1 - PAGE_SHIFT;
    localparam int WIN_HI     = 47;
    localparam int WIN_LO     = 41;
    localparam logic [WIN_HI-WIN_LO:0] WIN_TAG = 7'h7E;
    localparam int WIN_SX_BIT = 40;
    localparam int UC_CLR_W   = 8;
    localparam int ASN_W      = 8;
    localparam int MODES      = 4;
    localparam int SIZE_W     = 2;
    localparam int MAX_ALIGN  = (1 << ((1 << SIZE_W) - 1)) - 1;
    localparam int ALIGN_W    = $clog2(MAX_ALIGN + 1);

    localparam int ST_WR   = 0;
    localparam int ST_ACV  = 1;
    localparam int ST_FONR = 2;
    localparam int ST_FONW = 3;
    localparam int ST_BADVA = 4;
    localparam int ST_MISS = 5;
    localparam int ST_W    = 6;

    typedef enum logic [1:0] {
        MODE_KERN  = 2'd0,
        MODE_EXEC  = 2'd1,
        MODE_SUPER = 2'd2,
        MODE_USER  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_ALIGN     = 3'd1,
        FLT_PAGE      = 3'd2,
        FLT_ACV       = 3'd3,
        FLT_MISS_PTE  = 3'd4,
        FLT_MISS_DATA = 3'd5,
        FLT_MCHK      = 3'd6
    } fault_e;

    typedef struct packed {
        fault_e            fault;
        logic [ST_W-1:0]   status;
        logic [VA_W-1:0]   pa_raw;
        logic              ev_hit;
        logic              ev_miss;
        logic              ev_acv;
    } verdict_t;

    function automatic logic va_canonical(input logic [VA_W-1:0] va);
        return (&va[VA_W-1:SIGN_BIT]) || !(|va[VA_W-1:SIGN_BIT]);
    endfunction

    function automatic logic [VA_W-1:0] window_map(input logic [VA_W-1:0] va);
        logic [VA_W-1:0] r;
        r = '0;
        r[WIN_SX_BIT-1:0] = va[WIN_SX_BIT-1:0];
        r[PA_W-1:WIN_SX_BIT] = {(PA_W-WIN_SX_BIT){va[WIN_SX_BIT]}};
        return r;
    endfunction
endpackage

// File: rtl/dxc_mode_sel.sv
module dxc_mode_sel
    import dxc_pkg::*;
(
    input  mode_e cur_mode,
    input  mode_e alt_mode,
    input  logic  pc_low,
    input  logic  use_alt,
    output mode_e eff_mode
);
    always_comb begin
        if (!pc_low)
            eff_mode = cur_mode;
        else if (use_alt)
            eff_mode = alt_mode;
        else
            eff_mode = MODE_KERN;
    end
endmodule

// File: rtl/dxc_perm_eval.sv
module dxc_perm_eval
    import dxc_pkg::*;
(
    input  logic             is_write,
    input  mode_e            mode,
    input  logic [MODES-1:0] rd_en,
    input  logic [MODES-1:0] wr_en,
    input  logic             fonr,
    input  logic             fonw,
    output logic             viol,
    output fault_e           fault,
    output logic [ST_W-1:0]  status
);
    logic [MODES-1:0] en;
    logic             fault_on;
    logic             allowed;
    int               fo_bit;

    assign en       = is_write ? wr_en : rd_en;
    assign fault_on = is_write ? fonw : fonr;
    assign allowed  = en[mode];
    assign fo_bit   = is_write ? ST_FONW : ST_FONR;

    always_comb begin
        viol   = 1'b0;
        fault  = FLT_NONE;
        status = '0;
        if (!allowed) begin
            viol           = 1'b1;
            fault          = is_write ? FLT_PAGE : FLT_ACV;
            status[ST_WR]  = is_write;
            status[ST_ACV] = 1'b1;
            status[fo_bit] = fault_on;
        end else if (fault_on) begin
            viol           = 1'b1;
            fault          = FLT_PAGE;
            status[ST_WR]  = is_write;
            status[fo_bit] = 1'b1;
        end
    end
endmodule

// File: rtl/dxc_pa_final.sv
module dxc_pa_final
    import dxc_pkg::*;
(
    input  logic [VA_W-1:0] raw,
    input  logic            chk_en,
    output logic [PA_W-1:0] pa,
    output logic            uncache,
    output logic            mchk
);
    always_comb begin
        mchk    = chk_en && (|raw[VA_W-1:PA_W]);
        pa      = raw[PA_W-1:0];
        uncache = chk_en && !mchk && raw[PA_W-1];
        if (uncache)
            pa[PA_W-2 -: UC_CLR_W] = '0;
    end
endmodule

// File: rtl/dxc_counters.sv
module dxc_counters #(
    parameter int CNT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ev_valid,
    input  logic                         is_write,
    input  logic                         inc_hit,
    input  logic                         inc_miss,
    input  logic                         inc_acv,
    output logic [1:0][2:0][CNT_W-1:0]   cnt
);
    localparam int KINDS  = 2;
    localparam int EVENTS = 3;

    logic [EVENTS-1:0] ev;
    assign ev = {inc_acv, inc_miss, inc_hit};

    for (genvar k = 0; k < KINDS; k++) begin : g_kind
        for (genvar e = 0; e < EVENTS; e++) begin : g_ev
            always_ff @(posedge clk) begin
                if (rst)
                    cnt[k][e] <= '0;
                else if (ev_valid && (is_write == (k == 1)) && ev[e])
                    cnt[k][e] <= cnt[k][e] + 1'b1;
            end
        end
    end

    a_r13_one_event: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> $onehot0(ev))
        else $error("R13: more than one counter event in a cycle");

    a_r13_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ev_valid)) |-> $stable(cnt))
        else $error("R13: counter moved without a request");
endmodule

// File: rtl/dxc_xlate_check.sv
module dxc_xlate_check
    import dxc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic               req_write,
    input  logic               req_phys,
    input  logic               req_alt,
    input  logic               req_pte,
    input  logic [1:0]         cur_mode,
    input  logic [1:0]         alt_mode,
    input  logic               pc_low,
    input  logic [ASN_W-1:0]   asn,
    output logic [VPN_W-1:0]   lk_vpn,
    output logic [ASN_W-1:0]   lk_asn,
    input  logic               tlb_hit,
    input  logic [PPN_W-1:0]   tlb_ppn,
    input  logic [MODES-1:0]   tlb_rd_en,
    input  logic [MODES-1:0]   tlb_wr_en,
    input  logic               tlb_fonr,
    input  logic               tlb_fonw,
    output logic               out_valid,
    output logic [PA_W-1:0]    out_pa,
    output logic               out_uncache,
    output logic [2:0]         out_fault,
    output logic [ST_W-1:0]    out_status,
    output logic [CNT_W-1:0]   rd_hits,
    output logic [CNT_W-1:0]   rd_misses,
    output logic [CNT_W-1:0]   rd_viols,
    output logic [CNT_W-1:0]   wr_hits,
    output logic [CNT_W-1:0]   wr_misses,
    output logic [CNT_W-1:0]   wr_viols,
    output logic [CNT_W:0]     all_hits,
    output logic [CNT_W:0]     all_misses,
    output logic [CNT_W:0]     all_viols
);
    mode_e            eff_mode;
    logic             perm_viol;
    fault_e           perm_fault;
    logic [ST_W-1:0]  perm_status;
    verdict_t         v;
    logic [PA_W-1:0]  fin_pa;
    logic             fin_uc;
    logic             fin_mchk;
    logic [ALIGN_W-1:0] align_mask;
    logic             misaligned;
    logic             in_window;
    logic [1:0][2:0][CNT_W-1:0] cnt;

    assign lk_vpn = req_va[SIGN_BIT:PAGE_SHIFT];
    assign lk_asn = asn;

    assign align_mask = ALIGN_W'((1 << req_size) - 1);
    assign misaligned = |(req_va[ALIGN_W-1:0] & align_mask);
    assign in_window  = (req_va[WIN_HI:WIN_LO] == WIN_TAG);

    dxc_mode_sel u_mode (
        .cur_mode (mode_e'(cur_mode)),
        .alt_mode (mode_e'(alt_mode)),
        .pc_low   (pc_low),
        .use_alt  (req_alt),
        .eff_mode (eff_mode)
    );

    dxc_perm_eval u_perm (
        .is_write (req_write),
        .mode     (eff_mode),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .fonr     (tlb_fonr),
        .fonw     (tlb_fonw),
        .viol     (perm_viol),
        .fault    (perm_fault),
        .status   (perm_status)
    );

    // Check order: alignment, physical bypass, canonical form, window, lookup, permissions.
    always_comb begin
        v = '0;
        v.fault = FLT_NONE;
        if (misaligned) begin
            v.fault = FLT_ALIGN;
            v.status[ST_WR] = req_write;
        end else if (req_phys) begin
            v.pa_raw = req_va;
            v.ev_hit = 1'b1;
        end else if (!va_canonical(req_va)) begin
            v.fault = FLT_PAGE;
            v.status[ST_WR]    = req_write;
            v.status[ST_ACV]   = 1'b1;
            v.status[ST_BADVA] = 1'b1;
            v.ev_acv = 1'b1;
        end else if (in_window) begin
            if (mode_e'(cur_mode) != MODE_KERN) begin
                v.fault = FLT_ACV;
                v.status[ST_WR]  = req_write;
                v.status[ST_ACV] = 1'b1;
                v.ev_acv = 1'b1;
            end else begin
                v.pa_raw = window_map(req_va);
                v.ev_hit = 1'b1;
            end
        end else if (!tlb_hit) begin
            v.fault = req_pte ? FLT_MISS_PTE : FLT_MISS_DATA;
            v.status[ST_WR]   = req_write;
            v.status[ST_MISS] = 1'b1;
            v.ev_miss = 1'b1;
        end else begin
            v.pa_raw = {{(VA_W-PA_W){1'b0}}, tlb_ppn, req_va[PAGE_SHIFT-1:0]};
            if (perm_viol) begin
                v.fault  = perm_fault;
                v.status = perm_status;
                v.ev_acv = 1'b1;
            end else begin
                v.ev_hit = 1'b1;
            end
        end
    end

    dxc_pa_final u_fin (
        .raw     (v.pa_raw),
        .chk_en  (v.fault == FLT_NONE),
        .pa      (fin_pa),
        .uncache (fin_uc),
        .mchk    (fin_mchk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_pa      <= '0;
            out_uncache <= 1'b0;
            out_fault   <= FLT_NONE;
            out_status  <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_pa      <= fin_mchk ? '0 : fin_pa;
                out_uncache <= fin_uc;
                out_fault   <= fin_mchk ? FLT_MCHK : v.fault;
                out_status  <= fin_mchk ? '0 : v.status;
            end
        end
    end

    dxc_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (req_valid),
        .is_write (req_write),
        .inc_hit  (v.ev_hit),
        .inc_miss (v.ev_miss),
        .inc_acv  (v.ev_acv),
        .cnt      (cnt)
    );

    assign rd_hits    = cnt[0][0];
    assign rd_misses  = cnt[0][1];
    assign rd_viols   = cnt[0][2];
    assign wr_hits    = cnt[1][0];
    assign wr_misses  = cnt[1][1];
    assign wr_viols   = cnt[1][2];
    assign all_hits   = {1'b0, rd_hits}   + {1'b0, wr_hits};
    assign all_misses = {1'b0, rd_misses} + {1'b0, wr_misses};
    assign all_viols  = {1'b0, rd_viols}  + {1'b0, wr_viols};

    a_r1_align_status: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault == FLT_ALIGN) |-> (out_status[ST_W-1:1] == '0))
        else $error("R1: alignment fault carries extra status");

    a_r6_miss_flag: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_fault == FLT_MISS_PTE || out_fault == FLT_MISS_DATA))
            |-> (out_status[ST_MISS] && !out_status[ST_ACV]))
        else $error("R6: miss fault without miss status");

    a_r11_mchk_clean: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault == FLT_MCHK) |-> (out_status == '0 && !out_uncache))
        else $error("R11: machine check with status set");

    a_r12_uc_masked: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_uncache)
            |-> (out_pa[PA_W-2 -: UC_CLR_W] == '0 && out_fault == FLT_NONE))
        else $error("R12: uncacheable address not masked");

    a_r9_fonw_bits: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status[ST_FONW]) |-> (out_status[ST_WR] && out_fault == FLT_PAGE))
        else $error("R9: fault-on-write status outside a store page fault");
endmodule

// File: tb/test_dxc_xlate_check.sv
module test_dxc_xlate_check;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_va;
    logic [1:0]  req_size;
    logic        req_write, req_phys, req_alt, req_pte;
    logic [1:0]  cur_mode, alt_mode;
    logic        pc_low;
    logic [7:0]  asn;
    logic [29:0] lk_vpn;
    logic [7:0]  lk_asn;
    logic        tlb_hit;
    logic [30:0] tlb_ppn;
    logic [3:0]  tlb_rd_en, tlb_wr_en;
    logic        tlb_fonr, tlb_fonw;
    logic        out_valid;
    logic [43:0] out_pa;
    logic        out_uncache;
    logic [2:0]  out_fault;
    logic [5:0]  out_status;
    logic [15:0] rd_hits, rd_misses, rd_viols, wr_hits, wr_misses, wr_viols;
    logic [16:0] all_hits, all_misses, all_viols;

    int tests = 0;
    int fails = 0;
    int e_cnt [2][3];

    always #10 clk = ~clk;

    dxc_xlate_check i_dxc_xlate_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
        .req_alt(req_alt), .req_pte(req_pte), .cur_mode(cur_mode),
        .alt_mode(alt_mode), .pc_low(pc_low), .asn(asn), .lk_vpn(lk_vpn),
        .lk_asn(lk_asn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr),
        .tlb_fonw(tlb_fonw), .out_valid(out_valid), .out_pa(out_pa),
        .out_uncache(out_uncache), .out_fault(out_fault),
        .out_status(out_status), .rd_hits(rd_hits), .rd_misses(rd_misses),
        .rd_viols(rd_viols), .wr_hits(wr_hits), .wr_misses(wr_misses),
        .wr_viols(wr_viols), .all_hits(all_hits), .all_misses(all_misses),
        .all_viols(all_viols)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected verdict; ev: 0 none, 1 hit, 2 miss, 3 violation
    task automatic model(output logic [2:0] f, output logic [5:0] st,
                         output logic [43:0] pa, output logic uc, output int ev);
        logic [63:0] raw;
        logic [1:0]  m;
        logic [3:0]  en;
        logic        fo;
        f = 0; st = 0; pa = 0; uc = 0; ev = 0; raw = 0;
        m = pc_low ? (req_alt ? alt_mode : 2'd0) : cur_mode;
        if ((req_va & ((64'd1 << req_size) - 1)) != 0) begin
            f = 1; st = {5'd0, req_write};
        end else if (req_phys) begin
            raw = req_va; ev = 1;
        end else if (!(req_va[63:42] == '0 || req_va[63:42] == '1)) begin
            f = 2; st = 6'b010010 | {5'd0, req_write}; ev = 3;
        end else if (req_va[47:41] == 7'h7E) begin
            if (cur_mode != 0) begin
                f = 3; st = 6'b000010 | {5'd0, req_write}; ev = 3;
            end else begin
                raw = {20'd0, {4{req_va[40]}}, req_va[39:0]}; ev = 1;
            end
        end else if (!tlb_hit) begin
            f = req_pte ? 3'd4 : 3'd5; st = 6'b100000 | {5'd0, req_write}; ev = 2;
        end else begin
            raw = {20'd0, tlb_ppn, req_va[12:0]};
            en = req_write ? tlb_wr_en : tlb_rd_en;
            fo = req_write ? tlb_fonw : tlb_fonr;
            if (!en[m]) begin
                f = req_write ? 3'd2 : 3'd3; ev = 3;
                st = req_write ? {2'b00, fo, 1'b0, 2'b11} : {3'b000, fo, 2'b10};
            end else if (fo) begin
                f = 2; ev = 3;
                st = req_write ? 6'b001001 : 6'b000100;
            end else ev = 1;
        end
        if (f == 0) begin
            if (raw[63:44] != 0) f = 6;
            else begin
                pa = raw[43:0];
                if (pa[43]) begin uc = 1; pa[42:35] = 8'd0; end
            end
        end
    endtask

    task automatic go(input string req);
        logic [2:0]  ef;
        logic [5:0]  es;
        logic [43:0] ep;
        logic        eu;
        int          ev;
        model(ef, es, ep, eu, ev);
        if (ev != 0) e_cnt[req_write][ev-1]++;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid === 1'b1, {req, " valid"}, out_valid, 1);
        check(out_fault === ef, {req, " fault"}, out_fault, ef);
        check(out_status === es, {req, " status"}, out_status, es);
        if (ef == 0) begin
            check(out_pa === ep, {req, " pa"}, out_pa, ep);
            check(out_uncache === eu, {req, " R12 uncache"}, out_uncache, eu);
        end
        check(rd_hits == e_cnt[0][0] && wr_hits == e_cnt[1][0], "R13 hit counters",
              {rd_hits, wr_hits}, {e_cnt[0][0][15:0], e_cnt[1][0][15:0]});
        check(rd_misses == e_cnt[0][1] && wr_misses == e_cnt[1][1], "R13 miss counters",
              {rd_misses, wr_misses}, {e_cnt[0][1][15:0], e_cnt[1][1][15:0]});
        check(rd_viols == e_cnt[0][2] && wr_viols == e_cnt[1][2], "R13 viol counters",
              {rd_viols, wr_viols}, {e_cnt[0][2][15:0], e_cnt[1][2][15:0]});
        check(all_hits == rd_hits + wr_hits && all_misses == rd_misses + wr_misses
              && all_viols == rd_viols + wr_viols, "R13 sums", all_hits, rd_hits + wr_hits);
    endtask

    task automatic base();
        req_va = 64'h0000_0123_4567_8000; req_size = 2'd3; req_write = 0;
        req_phys = 0; req_alt = 0; req_pte = 0; cur_mode = 2'd3; alt_mode = 2'd2;
        pc_low = 0; asn = 8'h5A; tlb_hit = 1; tlb_ppn = 31'h0000_1234;
        tlb_rd_en = 4'hF; tlb_wr_en = 4'hF; tlb_fonr = 0; tlb_fonw = 0;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5C));
        req_valid = 0; base(); rst = 1;
        for (int k = 0; k < 2; k++) for (int e = 0; e < 3; e++) e_cnt[k][e] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(out_valid === 0 && all_hits === 0 && all_viols === 0 && all_misses === 0,
              "R13 reset state", out_valid, 0);
        check(lk_asn === 8'h5A, "lookup asn", lk_asn, 8'h5A);

        // R1: misaligned store on an invalid address -> alignment wins
        base(); req_va = 64'h8000_0000_0000_0004; req_write = 1; go("R1 store align");
        base(); req_va = 64'h0000_0000_0000_0001; req_size = 2'd1; go("R1 load align");
        base(); req_va = 64'h0000_0000_0000_0006; req_size = 2'd1; go("R1 aligned half");
        // R3 / R11 physical
        base(); req_phys = 1; req_va = 64'h0000_0000_0ABC_0000; go("R3 phys");
        base(); req_phys = 1; req_va = 64'h0004_0000_0000_0000; go("R11 phys mchk");
        base(); req_phys = 1; req_va = 64'h0000_0800_0000_FF00; go("R12 phys uncache");
        // R4 invalid address
        base(); req_va = 64'h0001_0000_0000_0000; go("R4 bad va load");
        base(); req_va = 64'h0001_0000_0000_0000; req_write = 1; go("R4 bad va store");
        // R5 window
        base(); cur_mode = 0; req_va = 64'hFFFF_FD00_0000_1000 | 64'h0000_0100_0000_0000;
        go("R5 window bit40 set");
        base(); cur_mode = 0; req_va = 64'hFFFF_FC12_3456_7000; go("R5 window bit40 clear");
        base(); cur_mode = 2; pc_low = 1; req_va = 64'hFFFF_FC12_3456_7000; go("R5 window user");
        // R6 misses
        base(); tlb_hit = 0; req_pte = 1; go("R6 miss pte");
        base(); tlb_hit = 0; req_write = 1; go("R6 miss data store");
        // R7..R10 permissions
        base(); go("R7 hit load");
        base(); req_write = 1; tlb_wr_en = 4'b0111; tlb_fonw = 1; go("R8 store denied fonw");
        base(); req_write = 1; tlb_wr_en = 4'b0111; go("R8 store denied");
        base(); req_write = 1; tlb_fonw = 1; go("R9 store fonw");
        base(); tlb_rd_en = 4'b0111; tlb_fonr = 1; go("R10 load denied fonr");
        base(); tlb_fonr = 1; go("R10 load fonr");
        // R2 mode selection
        base(); pc_low = 1; tlb_rd_en = 4'b0001; go("R2 pc kernel");
        base(); pc_low = 1; req_alt = 1; tlb_rd_en = 4'b0001; go("R2 alt denied");
        base(); pc_low = 1; req_alt = 1; tlb_rd_en = 4'b0100; go("R2 alt allowed");
        // R12 uncacheable via lookup
        base(); tlb_ppn = 31'h7FFF_FFFF; go("R12 tlb uncache");

        for (int i = 0; i < 400; i++) begin
            logic [63:0] r;
            int c;
            base();
            r = {$urandom, $urandom};
            c = $urandom % 6;
            case (c)
                0: req_va = {22'd0, r[41:0]};
                1: req_va = {22'h3FFFFF, r[41:0]};
                2: req_va = {16'hFFFF, 7'h7E, r[40:0]};
                3: req_va = r | 64'h0100_0000_0000_0000;
                4: begin req_phys = 1; req_va = (r[6] ? r : {20'd0, r[43:0]}); end
                default: req_va = r;
            endcase
            req_size = 2'($urandom); req_write = 1'($urandom);
            if ($urandom % 2) req_va[2:0] = 3'd0;
            req_alt = 1'($urandom); req_pte = 1'($urandom);
            cur_mode = 2'($urandom); alt_mode = 2'($urandom); pc_low = 1'($urandom);
            tlb_hit = ($urandom % 4) != 0; tlb_ppn = 31'($urandom);
            tlb_rd_en = 4'($urandom); tlb_wr_en = 4'($urandom);
            tlb_fonr = ($urandom % 4) == 0; tlb_fonw = ($urandom % 4) == 0;
            go("R2 R7 random");
        end

        // R13: idle cycles leave counters untouched
        base();
        repeat (3) @(negedge clk);
        check(out_valid === 0, "R13 idle valid", out_valid, 0);
        check(all_hits == e_cnt[0][0] + e_cnt[1][0], "R13 idle hits", all_hits,
              e_cnt[0][0] + e_cnt[1][0]);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule